// File: doc/BRIEF.md
# I2C Wait-State Release Controller

This block decides when a stalled I2C interface may let go of SCL. After a byte or an acknowledge, the shift engine pulses `wait_start`. The controller then raises `scl_hold`, and the clock stays low until software performs a qualifying cancel operation. Software cancels the wait in one of these ways:

- writing the shift register, which sends a byte;
- setting the release bit, which resumes reception or closes a transmission with no new byte;
- setting the start or stop bit, which is honoured only in master mode;
- setting the exit-communication bit;
- clearing the interface enable.

When the wait ends, the controller drops `scl_hold`. In the same clock it emits a one-cycle `rel_pulse` together with an action code that tells the shift engine how to continue. The shift engine takes the code on the following clock.

Several rules can stop a release. The wake-up mode level blocks every release. In slave mode, start and stop strobes are ignored. Only one cancel is accepted for each wait. A non-abort cancel that arrives after a release and before the next wait sets a sticky error flag. It has no other effect, so a late data write cannot disturb the line timing.

Top module: `wait_release_ctrl`

## Requirements
- R1: After reset, `scl_hold`, `rel_pulse` and `dbl_err` are 0 and `rel_act` is 0.
- R2: While `scl_hold` is 0, a `wait_start` pulse sets `scl_hold` on the next clock. Cancel strobes in the same cycle as that `wait_start` are ignored.
- R3: A qualifying cancel strobe in a cycle with `scl_hold`=1 and `wkup_mode`=0 has the following effect on the next clock edge: `scl_hold` clears, `rel_pulse` is 1 for exactly one cycle, and `rel_act` carries the action code for that cycle. In every other cycle `rel_act` is 0.
- R4: The action codes are RX=0 for the release bit, TX=1 for a shift-register write, RESTART=2 for the start bit, STOP=3 for the stop bit, and ABORT=4 for the exit-communication bit or an enable clear.
- R5: If several qualifying strobes arrive in one cycle, exactly one release is produced. The strobe chosen is the first in this order: exit or enable clear, then stop, then start, then data write, then release bit.
- R6: With `is_master`=0, start and stop strobes do not qualify. They do not release the wait, and they do not count as a second cancel.
- R7: While `wkup_mode`=1, no strobe releases the wait, and `scl_hold` stays 1.
- R8: A non-abort qualifying strobe that arrives after a release and before the next `wait_start` produces no release and sets `dbl_err`. `dbl_err` then stays 1 until reset.
- R9: An exit or enable-clear strobe that arrives after a release does not set `dbl_err` and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wait_start | input | 1 | Shift engine: a wait state begins |
| is_master | input | 1 | 1 = master mode |
| wkup_mode | input | 1 | Wake-up mode level; blocks every release |
| shift_wr | input | 1 | Strobe: shift register written |
| rel_set | input | 1 | Strobe: release bit set |
| sta_set | input | 1 | Strobe: start bit set |
| sto_set | input | 1 | Strobe: stop bit set |
| exit_set | input | 1 | Strobe: exit-communication bit set |
| en_clr | input | 1 | Strobe: interface enable cleared |
| scl_hold | output | 1 | Wait state active (SCL held low) |
| rel_pulse | output | 1 | One-cycle release indication |
| rel_act | output | 3 | Action code during `rel_pulse`, otherwise 0 |
| dbl_err | output | 1 | Sticky double-cancel flag |

## Verification
The embedded assertions check four rules on every cycle:

- a release pulse only ends a held wait, and it never lasts two cycles;
- a restart or stop action only appears when master mode was active;
- wake-up mode keeps a held wait held;
- the double-cancel flag never falls.

Some behaviour can only be shown by the scored scenarios: that each strobe maps to its own code, the priority between simultaneous strobes, and that slave-mode start and stop leave the hold in place. The scenarios also show that a late write after a release sets the error flag while an abort in the same position does not.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  localparam int ACT_W = 3;

  typedef enum logic [ACT_W-1:0] {
    ACT_RX      = 3'd0,
    ACT_TX      = 3'd1,
    ACT_RESTART = 3'd2,
    ACT_STOP    = 3'd3,
    ACT_ABORT   = 3'd4
  } rel_act_e;

  typedef struct packed {
    logic data_wr;
    logic rel;
    logic sta;
    logic sto;
    logic exit_req;
    logic en_off;
  } cancel_ev_t;
endpackage

// File: rtl/wrc_rst_sync.sv
module wrc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/wrc_arbiter.sv
module wrc_arbiter
  import wrc_pkg::*;
(
  input  cancel_ev_t     ev,
  input  logic           is_master,
  output logic           cand_vld,
  output logic           cand_abort,
  output logic [ACT_W-1:0] cand_act
);
  logic sto_ok, sta_ok;

  // start/stop qualify only in master mode
  assign sto_ok = ev.sto & is_master;
  assign sta_ok = ev.sta & is_master;

  always_comb begin
    cand_vld   = 1'b1;
    cand_abort = 1'b0;
    cand_act   = ACT_RX;
    if (ev.exit_req || ev.en_off) begin
      cand_abort = 1'b1;
      cand_act   = ACT_ABORT;
    end else if (sto_ok) begin
      cand_act   = ACT_STOP;
    end else if (sta_ok) begin
      cand_act   = ACT_RESTART;
    end else if (ev.data_wr) begin
      cand_act   = ACT_TX;
    end else if (ev.rel) begin
      cand_act   = ACT_RX;
    end else begin
      cand_vld   = 1'b0;
    end
  end
endmodule

// File: rtl/wrc_tracker.sv
module wrc_tracker
  import wrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_start,
  input  logic             wkup_mode,
  input  logic             is_master,
  input  logic             cand_vld,
  input  logic             cand_abort,
  input  logic [ACT_W-1:0] cand_act,
  output logic             hold,
  output logic             rel_pulse,
  output logic [ACT_W-1:0] rel_act,
  output logic             dbl_err
);
  logic             hold_q, hold_d;
  logic             used_q, used_d;
  logic             pulse_q, pulse_d;
  logic [ACT_W-1:0] act_q, act_d;
  logic             err_q, err_d;

  always_comb begin
    hold_d  = hold_q;
    used_d  = used_q;
    pulse_d = 1'b0;
    act_d   = ACT_RX;
    err_d   = err_q;
    if (!hold_q && wait_start) begin
      hold_d = 1'b1;
      used_d = 1'b0;
    end else if (hold_q) begin
      if (cand_vld && !wkup_mode) begin
        hold_d  = 1'b0;
        used_d  = 1'b1;
        pulse_d = 1'b1;
        act_d   = cand_act;
      end
    end else if (used_q && cand_vld && !cand_abort) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      used_q  <= 1'b0;
      pulse_q <= 1'b0;
      act_q   <= ACT_RX;
      err_q   <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      used_q  <= used_d;
      pulse_q <= pulse_d;
      act_q   <= act_d;
      err_q   <= err_d;
    end
  end

  assign hold      = hold_q;
  assign rel_pulse = pulse_q;
  assign rel_act   = act_q;
  assign dbl_err   = err_q;

  // R3
  pulse_ends_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |-> ($past(hold_q) && !hold_q));

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |=> !rel_pulse);

  // R6
  master_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_pulse && (rel_act == ACT_STOP || rel_act == ACT_RESTART)) |-> $past(is_master));

  // R7
  wkup_keeps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && wkup_mode) |=> hold_q);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_err |=> dbl_err);

  // R4
  act_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |-> (rel_act <= ACT_ABORT));
endmodule

// File: rtl/wait_release_ctrl.sv
module wait_release_ctrl
  import wrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_start,
  input  logic             is_master,
  input  logic             wkup_mode,
  input  logic             shift_wr,
  input  logic             rel_set,
  input  logic             sta_set,
  input  logic             sto_set,
  input  logic             exit_set,
  input  logic             en_clr,
  output logic             scl_hold,
  output logic             rel_pulse,
  output logic [ACT_W-1:0] rel_act,
  output logic             dbl_err
);
  logic             rst_n_int;
  cancel_ev_t       ev;
  logic             cand_vld, cand_abort;
  logic [ACT_W-1:0] cand_act;

  wrc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign ev = '{data_wr: shift_wr, rel: rel_set, sta: sta_set,
                sto: sto_set, exit_req: exit_set, en_off: en_clr};

  wrc_arbiter u_arb (
    .ev         (ev),
    .is_master  (is_master),
    .cand_vld   (cand_vld),
    .cand_abort (cand_abort),
    .cand_act   (cand_act)
  );

  wrc_tracker u_trk (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wait_start (wait_start),
    .wkup_mode  (wkup_mode),
    .is_master  (is_master),
    .cand_vld   (cand_vld),
    .cand_abort (cand_abort),
    .cand_act   (cand_act),
    .hold       (scl_hold),
    .rel_pulse  (rel_pulse),
    .rel_act    (rel_act),
    .dbl_err    (dbl_err)
  );
endmodule

// File: tb/sim_wait_release_ctrl.sv
module sim_wait_release_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_start = 0, is_master = 1, wkup_mode = 0;
  logic shift_wr = 0, rel_set = 0, sta_set = 0, sto_set = 0, exit_set = 0, en_clr = 0;
  logic scl_hold, rel_pulse, dbl_err;
  logic [2:0] rel_act;

  int n_chk = 0, n_bad = 0;
  logic [2:0] expq[$];
  bit done = 0;

  localparam logic [5:0] E_DATA = 6'b100000, E_REL = 6'b010000, E_STA = 6'b001000,
                         E_STO = 6'b000100, E_EXIT = 6'b000010, E_ENC = 6'b000001;

  always #10 clk = ~clk;

  wait_release_ctrl u0 (.*);

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fire(input logic [5:0] ev, input bit expect_rel, input logic [2:0] a);
    {shift_wr, rel_set, sta_set, sto_set, exit_set, en_clr} = ev;
    if (expect_rel) expq.push_back(a);
    @(negedge clk);
    {shift_wr, rel_set, sta_set, sto_set, exit_set, en_clr} = '0;
  endtask

  task automatic open_wait();
    wait_start = 1;
    @(negedge clk);
    wait_start = 0;
  endtask

  // monitor: pops scoreboard on each release pulse
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rel_pulse) begin
        if (expq.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R3 unexpected pulse actual=%0d expected=none", rel_act);
        end else chk("R4/R5 action", rel_act, expq.pop_front());
      end else if (rel_act !== 3'd0) chk("R3 idle code", rel_act, 3'd0);
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hold", scl_hold, 0);
    chk("R1 pulse", rel_pulse, 0);
    chk("R1 err", dbl_err, 0);
    chk("R1 act", rel_act, 0);
    // R2 wait opens; strobe with wait_start ignored
    wait_start = 1; shift_wr = 1;
    @(negedge clk);
    wait_start = 0; shift_wr = 0;
    chk("R2 hold set", scl_hold, 1);
    chk("R2 no err", dbl_err, 0);
    // R3/R4 TX
    fire(E_DATA, 1, 3'd1);
    chk("R3 hold cleared", scl_hold, 0);
    open_wait(); fire(E_REL, 1, 3'd0);
    open_wait(); fire(E_STA, 1, 3'd2);
    open_wait(); fire(E_STO, 1, 3'd3);
    open_wait(); fire(E_EXIT, 1, 3'd4);
    open_wait(); fire(E_ENC, 1, 3'd4);
    // R5 priority
    open_wait(); fire(6'b111111, 1, 3'd4);
    open_wait(); fire(E_DATA|E_REL|E_STA|E_STO, 1, 3'd3);
    open_wait(); fire(E_DATA|E_REL|E_STA, 1, 3'd2);
    open_wait(); fire(E_DATA|E_REL, 1, 3'd1);
    // R6 slave ignores start/stop
    is_master = 0;
    open_wait(); fire(E_STA, 0, 0); fire(E_STO, 0, 0);
    chk("R6 hold kept", scl_hold, 1);
    fire(E_STO|E_REL, 1, 3'd0);
    fire(E_STA, 0, 0);
    chk("R6 no err", dbl_err, 0);
    is_master = 1;
    // R7 wake-up mode blocks
    open_wait(); wkup_mode = 1;
    fire(E_DATA, 0, 0); fire(E_EXIT, 0, 0);
    chk("R7 hold kept", scl_hold, 1);
    wkup_mode = 0;
    fire(E_REL, 1, 3'd0);
    // R9 abort after release
    fire(E_EXIT, 0, 0); fire(E_ENC, 0, 0);
    chk("R9 no err", dbl_err, 0);
    // R8 second cancel
    fire(E_DATA, 0, 0);
    chk("R8 err set", dbl_err, 1);
    chk("R8 hold low", scl_hold, 0);
    open_wait();
    chk("R8 err sticky", dbl_err, 1);
    fire(E_REL, 1, 3'd0);
    @(negedge clk);
    chk("R3 queue drained", 3'(expq.size()), 0);
    done = 1;
    report();
  end
endmodule